// File: doc/BRIEF.md
# Reset Vector Fetch Sequencer

This block performs the processor-side start-up sequence that follows a hardware reset. While reset is held, and for as long afterwards as nothing else changes it, the status word sits in a fixed supervisor state. The interrupt mask is at its highest level, tracing is off and the condition flags are cleared. Once reset is released, the sequencer reads a four-word boot vector from address zero through a word-wide read port with a request/acknowledge handshake. Each access is tagged with the supervisor-program function code.

The first two words become the initial supervisor stack pointer. The last two become the initial program counter. In both cases the more significant word comes first. After the fourth word arrives, a one-cycle done pulse tells the instruction fetch unit to begin at the loaded program counter. Nothing is written to memory, because no earlier context is kept.

A separate software reset request only drives the external reset output, for a fixed 124-cycle window. It leaves the sequencer, the status word and the loaded pointers untouched.

Top module: `reset_vector_seq`

## Requirements
- R1: While rst_ni is low, sr_o reads 16'h2700 (bit 15 trace = 0, bit 13 supervisor = 1, bits 10:8 interrupt mask = 7, bits 4:0 condition flags = 0). In the same state rd_req_o, boot_done_o and ext_rst_o are 0, and ssp_o and pc_o are 0.
- R2: After reset is released, rd_req_o rises following the first clock edge. Reads go to byte addresses 0, 2, 4 and 6 in that order, one at a time, and rd_addr_o is 0 whenever no read is requested.
- R3: rd_fc_o is 3'b110 (supervisor program) while rd_req_o is high and 3'b000 otherwise.
- R4: A read stays requested with an unchanged address for as many cycles as the acknowledge takes. A word is taken only on a clock edge where rd_req_o and rd_ack_i are both high, and rd_data_i is ignored at any other time.
- R5: The word acknowledged at address 0 is loaded into ssp_o[31:15+1], and the word at address 2 into ssp_o[15:0], each on its acknowledge edge.
- R6: The word acknowledged at address 4 is loaded into pc_o[31:16], and the word at address 6 into pc_o[15:0], each on its acknowledge edge.
- R7: boot_done_o is high for exactly one cycle, the cycle after the fourth acknowledge, once per reset. After it, no further read is requested and no write port exists.
- R8: With ext_rst_o low, a high sw_rst_req_i on a clock edge raises ext_rst_o from the next cycle for exactly 124 cycles.
- R9: A sw_rst_req_i seen on any edge where ext_rst_o is already high is ignored: it neither extends nor restarts the window. A request on the edge right after the window ends starts a new one.
- R10: Software reset requests, at any time including during the vector reads, change none of sr_o, rd_req_o, rd_addr_o, ssp_o, pc_o or boot_done_o. sr_o keeps 16'h2700 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| rd_req_o | output | 1 | Vector word read request |
| rd_addr_o | output | ADDR_W (24) | Byte address of the requested word |
| rd_fc_o | output | 3 | Access-type function code |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | WORD_W (16) | Read data word |
| sr_o | output | 16 | Status word |
| ssp_o | output | 2*WORD_W (32) | Initial supervisor stack pointer |
| pc_o | output | 2*WORD_W (32) | Initial program counter |
| boot_done_o | output | 1 | One-cycle start pulse for instruction fetch |
| sw_rst_req_i | input | 1 | Software request for an external reset pulse |
| ext_rst_o | output | 1 | External reset output |

## Verification
The bench varies acknowledge latency from zero wait states up to a 40-cycle stall. A design that drops or moves the request early would load the wrong word, and one that samples data without an acknowledge would pick up the junk value driven between reads. Software requests arrive at periods of exactly 124 and 125 cycles and in dense bursts. An off-by-one window length, a retriggerable timer or a missed back-to-back start each shows up at the pulse edges. Requests land in the middle of the vector reads, so a sequencer that restarted or skipped a word on a software reset would show a wrong pointer, an extra read or a second done pulse.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

  localparam int unsigned SR_W        = 16;
  localparam int unsigned SR_T_BIT    = 15;
  localparam int unsigned SR_S_BIT    = 13;
  localparam int unsigned SR_MASK_LSB = 8;
  localparam int unsigned SR_MASK_MAX = 7;

  // trace off, supervisor on, mask at top level, condition flags clear
  localparam logic [SR_W-1:0] SR_RESET =
      (SR_W'(1) << SR_S_BIT) | (SR_W'(SR_MASK_MAX) << SR_MASK_LSB);

  localparam logic [2:0] FC_SUP_PROG = 3'b110;
  localparam logic [2:0] FC_IDLE     = 3'b000;

  localparam int unsigned PTR_WORDS = 2;
  localparam int unsigned N_PTRS    = 2;
  localparam int unsigned VEC_WORDS = PTR_WORDS * N_PTRS;

  typedef enum logic [1:0] {
    SEQ_START = 2'd0,
    SEQ_FETCH = 2'd1,
    SEQ_DONE  = 2'd2,
    SEQ_RUN   = 2'd3
  } seq_state_t;

endpackage

// File: rtl/rvs_fetch_ctrl.sv
module rvs_fetch_ctrl
  import rvs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned N_WORDS    = VEC_WORDS,
  parameter int unsigned WORD_BYTES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_ack_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [2:0]        rd_fc_o,
  output logic              word_we_o,
  output logic [((N_WORDS > 1) ? $clog2(N_WORDS) : 1)-1:0] word_idx_o,
  output logic              done_o
);

  localparam int unsigned IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam int unsigned SHIFT = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 0;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

  seq_state_t        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              idx_en;
  logic              take_word;
  logic [ADDR_W-1:0] addr_base;

  assign rd_req_o  = (state_q == SEQ_FETCH);
  assign take_word = rd_req_o & rd_ack_i;
  assign idx_en    = take_word | (state_q == SEQ_START);

  // next-state process
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      SEQ_START: begin
        state_d = SEQ_FETCH;
        idx_d   = '0;
      end
      SEQ_FETCH: begin
        if (rd_ack_i) begin
          if (idx_q == LAST_IDX) begin
            state_d = SEQ_DONE;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      SEQ_DONE: state_d = SEQ_RUN;
      SEQ_RUN:  state_d = SEQ_RUN;
      default:  state_d = SEQ_START;
    endcase
  end

  // register process
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_START;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  assign addr_base  = {{(ADDR_W-IDX_W){1'b0}}, idx_q};
  assign rd_addr_o  = rd_req_o ? (addr_base << SHIFT) : '0;
  assign rd_fc_o    = rd_req_o ? FC_SUP_PROG : FC_IDLE;
  assign word_we_o  = take_word;
  assign word_idx_o = idx_q;
  assign done_o     = (state_q == SEQ_DONE);

  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

  // R2
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && rd_ack_i && rd_addr_o != '0 && !done_o && idx_q != LAST_IDX)
      |=> (rd_addr_o == $past(rd_addr_o) + ADDR_W'(WORD_BYTES)));

  // R7
  done_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(rd_req_o && rd_ack_i));

  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !rd_req_o));

endmodule

// File: rtl/rvs_vector_asm.sv
module rvs_vector_asm
  import rvs_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned IDX_W  = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          word_we_i,
  input  logic [IDX_W-1:0]              word_idx_i,
  input  logic [WORD_W-1:0]             word_i,
  output logic [PTR_WORDS*WORD_W-1:0]   ssp_o,
  output logic [PTR_WORDS*WORD_W-1:0]   pc_o
);

  localparam int unsigned PTR_W = PTR_WORDS * WORD_W;

  logic [WORD_W-1:0]           slot_q [VEC_WORDS];
  logic [N_PTRS-1:0][PTR_W-1:0] ptr_v;

  for (genvar k = 0; k < VEC_WORDS; k++) begin : g_slot
    logic              slot_en;
    logic [WORD_W-1:0] slot_d;

    assign slot_en = word_we_i && (word_idx_i == IDX_W'(k));
    assign slot_d  = word_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q[k] <= '0;
      end else if (slot_en) begin
        slot_q[k] <= slot_d;
      end
    end
  end

  // within each pointer the earlier word is the more significant one
  for (genvar p = 0; p < N_PTRS; p++) begin : g_ptr
    for (genvar w = 0; w < PTR_WORDS; w++) begin : g_half
      assign ptr_v[p][(PTR_WORDS-1-w)*WORD_W +: WORD_W] = slot_q[p*PTR_WORDS + w];
    end
  end

  assign ssp_o = ptr_v[0];
  assign pc_o  = ptr_v[1];

  // R5
  ptr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_we_i |=> ($stable(ssp_o) && $stable(pc_o)));

endmodule

// File: rtl/rvs_ext_rst_timer.sv
module rvs_ext_rst_timer #(
  parameter int unsigned PULSE_CYCLES = 124
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_req_i,
  output logic ext_rst_o
);

  localparam int unsigned CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES - 1);

  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = active_q | sw_req_i;

  // next-state process
  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    if (active_q) begin
      if (cnt_q == '0) begin
        active_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (sw_req_i) begin
      active_d = 1'b1;
      cnt_d    = CNT_LOAD;
    end
  end

  // register process
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (cnt_en) begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  assign ext_rst_o = active_q;

  // R8
  ext_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_rst_o) |-> $past(sw_req_i));

  // R8
  ext_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_rst_o && cnt_q != '0) |=> ext_rst_o);

  // R9
  ext_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_rst_o && sw_req_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/reset_vector_seq.sv
module reset_vector_seq
  import rvs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned RST_CYCLES = 124
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  output logic                        rd_req_o,
  output logic [ADDR_W-1:0]           rd_addr_o,
  output logic [2:0]                  rd_fc_o,
  input  logic                        rd_ack_i,
  input  logic [WORD_W-1:0]           rd_data_i,
  output logic [SR_W-1:0]             sr_o,
  output logic [PTR_WORDS*WORD_W-1:0] ssp_o,
  output logic [PTR_WORDS*WORD_W-1:0] pc_o,
  output logic                        boot_done_o,
  input  logic                        sw_rst_req_i,
  output logic                        ext_rst_o
);

  localparam int unsigned IDX_W      = (VEC_WORDS > 1) ? $clog2(VEC_WORDS) : 1;
  localparam int unsigned WORD_BYTES = WORD_W / 8;

  logic             word_we;
  logic [IDX_W-1:0] word_idx;
  logic [SR_W-1:0]  sr_q, sr_d;

  rvs_fetch_ctrl #(
    .ADDR_W     (ADDR_W),
    .N_WORDS    (VEC_WORDS),
    .WORD_BYTES (WORD_BYTES)
  ) u_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_ack_i   (rd_ack_i),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_fc_o    (rd_fc_o),
    .word_we_o  (word_we),
    .word_idx_o (word_idx),
    .done_o     (boot_done_o)
  );

  rvs_vector_asm #(
    .WORD_W (WORD_W),
    .IDX_W  (IDX_W)
  ) u_asm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_we_i  (word_we),
    .word_idx_i (word_idx),
    .word_i     (rd_data_i),
    .ssp_o      (ssp_o),
    .pc_o       (pc_o)
  );

  rvs_ext_rst_timer #(
    .PULSE_CYCLES (RST_CYCLES)
  ) u_ext (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sw_req_i  (sw_rst_req_i),
    .ext_rst_o (ext_rst_o)
  );

  // status word: forced to the supervisor start state, held afterwards
  assign sr_d = sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= SR_RESET;
    end else begin
      sr_q <= sr_d;
    end
  end

  assign sr_o = sr_q;

  // R10
  sw_no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boot_done_o || (!rd_req_o && !$rose(rd_req_o) && ssp_o != '0 && pc_o != '0))
      |=> !rd_req_o);

endmodule

// File: tb/tb_reset_vector_seq.sv
module tb_reset_vector_seq;

  localparam int RST_LEN = 124;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_req;
  logic [23:0] rd_addr;
  logic [2:0]  rd_fc;
  logic        rd_ack;
  logic [15:0] rd_data;
  logic [15:0] sr;
  logic [31:0] ssp;
  logic [31:0] pc;
  logic        done;
  logic        sw_req;
  logic        ext_rst;

  always #5 clk = ~clk;

  reset_vector_seq dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .rd_req_o     (rd_req),
    .rd_addr_o    (rd_addr),
    .rd_fc_o      (rd_fc),
    .rd_ack_i     (rd_ack),
    .rd_data_i    (rd_data),
    .sr_o         (sr),
    .ssp_o        (ssp),
    .pc_o         (pc),
    .boot_done_o  (done),
    .sw_rst_req_i (sw_req),
    .ext_rst_o    (ext_rst)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // reference model state
  int          m_phase;     // 0 waiting, 1 reading, 2 done cycle, 3 running
  int          m_idx;
  logic [31:0] m_ssp;
  logic [31:0] m_pc;
  int          ext_start;
  int          cyc;
  int          wait_cnt;
  int          dones;
  int          rst_hold;
  int          dly_mode;
  int          sw_period;
  bit          in_rst;
  logic [15:0] vec [4];

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  function automatic int ack_delay(input int mode, input int idx);
    if (mode == 0) return 0;
    if (mode == 1) return (idx * 3 + 1) % 5;
    return (idx == 2) ? 40 : 1;
  endfunction

  task automatic step();
    bit          e_req;
    bit          e_ext;
    bit          do_ack;
    bit          do_sw;
    bit          rst_low;
    int          d;
    logic [23:0] e_addr;
    @(negedge clk);
    // compare against the model
    e_req  = (m_phase == 1);
    e_addr = e_req ? 24'(m_idx * 2) : 24'd0;
    d      = cyc - ext_start;
    e_ext  = (d >= 1) && (d <= RST_LEN);
    check(sr == 16'h2700, in_rst ? "R1 sr_o" : "R10 sr_o", 32'(sr), 32'h2700);
    check(rd_req == e_req, "R4 rd_req_o", 32'(rd_req), 32'(e_req));
    check(rd_addr == e_addr, "R2 rd_addr_o", 32'(rd_addr), 32'(e_addr));
    check(rd_fc == (e_req ? 3'b110 : 3'b000), "R3 rd_fc_o", 32'(rd_fc),
          e_req ? 32'd6 : 32'd0);
    check(ssp == m_ssp, "R5 ssp_o", ssp, m_ssp);
    check(pc == m_pc, "R6 pc_o", pc, m_pc);
    check(done == (m_phase == 2), "R7 boot_done_o", 32'(done), 32'(m_phase == 2));
    check(ext_rst == e_ext, "R8/R9 ext_rst_o", 32'(ext_rst), 32'(e_ext));

    // drive inputs for the coming edge
    rst_low = (rst_hold > 0);
    if (rst_hold > 0) rst_hold--;
    rst_n   = !rst_low;
    do_ack  = !rst_low && e_req && (wait_cnt >= ack_delay(dly_mode, m_idx));
    do_sw   = !rst_low && (sw_period != 0) && (cyc % sw_period == 0);
    rd_ack  = do_ack;
    rd_data = do_ack ? vec[m_idx] : 16'hDEAD;
    sw_req  = do_sw;

    // advance the model
    if (rst_low) begin
      in_rst    = 1'b1;
      m_phase   = 0;
      m_idx     = 0;
      m_ssp     = '0;
      m_pc      = '0;
      ext_start = -100000;
      wait_cnt  = 0;
    end else begin
      in_rst = 1'b0;
      if (do_sw && !e_ext) ext_start = cyc;
      case (m_phase)
        0: begin m_phase = 1; m_idx = 0; wait_cnt = 0; end
        1: begin
          if (do_ack) begin
            case (m_idx)
              0: m_ssp[31:16] = vec[0];
              1: m_ssp[15:0]  = vec[1];
              2: m_pc[31:16]  = vec[2];
              default: m_pc[15:0] = vec[3];
            endcase
            m_idx++;
            wait_cnt = 0;
            if (m_idx == 4) begin
              m_phase = 2;
              dones++;
            end
          end else begin
            wait_cnt++;
          end
        end
        2: m_phase = 3;
        default: m_phase = 3;
      endcase
    end
    cyc++;
  endtask

  task automatic run_boot(input logic [15:0] w0, input logic [15:0] w1,
                          input logic [15:0] w2, input logic [15:0] w3,
                          input int mode, input int swp, input int ncyc);
    int done_seen;
    vec[0]    = w0;
    vec[1]    = w1;
    vec[2]    = w2;
    vec[3]    = w3;
    dly_mode  = mode;
    sw_period = swp;
    rst_hold  = 3;
    dones     = 0;
    done_seen = 0;
    for (int i = 0; i < ncyc; i++) begin
      step();
      if (done) done_seen++;
    end
    // R7: exactly one done pulse per reset, seen at the port
    check(done_seen == 1, "R7 done pulse count", 32'(done_seen), 32'd1);
    check(dones == 1, "R7 vector completed", 32'(dones), 32'd1);
  endtask

  initial begin
    rst_n     = 1'b0;
    rd_ack    = 1'b0;
    rd_data   = 16'h0000;
    sw_req    = 1'b0;
    in_rst    = 1'b1;
    m_phase   = 0;
    m_idx     = 0;
    m_ssp     = '0;
    m_pc      = '0;
    ext_start = -100000;
    cyc       = 0;
    wait_cnt  = 0;
    dones     = 0;
    rst_hold  = 0;
    dly_mode  = 0;
    sw_period = 0;

    // R1, R2, R5, R6: zero wait states, no software requests
    run_boot(16'h00FF, 16'hFF00, 16'h1234, 16'hABCD, 0, 0, 30);
    // R4, R10: uneven latency, software requests during the reads
    run_boot(16'hFFFF, 16'hFFFE, 16'h0000, 16'h0400, 1, 9, 300);
    // R4, R9: 40-cycle stall, requests at exactly the window length
    run_boot(16'hA5A5, 16'h5A5A, 16'hC3C3, 16'h3C3C, 2, RST_LEN, 600);
    // R9: back-to-back restart one cycle after the window
    run_boot(16'h8001, 16'h7FFE, 16'h0F0F, 16'hF0F0, 1, RST_LEN + 1, 500);
    // R8, R9: dense requests, mostly ignored
    run_boot(16'h1111, 16'h2222, 16'h3333, 16'h4444, 0, 7, 400);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R7 watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule